// File: doc/BRIEF.md
# Bidirectional Multiplexed Bank Latch

This block links one narrow bus, side A, to two banks of the same width, bank 1 and bank 2. In the outbound direction a word on A can be kept in two separate holding stages, one for each bank. Each bank then drives its own copy of the word under its own active-low drive control. This lets one A stream feed the two banks with different words, for example an address to one bank and data to the other. In the inbound direction each bank has its own holding stage. A bank-select input picks which held word returns to A, under a third active-low drive control.

Each holding stage is a transparent stage in a synchronous design. While its capture enable is high, its output follows its input in the same cycle, and every rising clock edge stores the input. When the enable is low, the stage presents the word stored at the last rising edge where the enable was high. Each port is split into an input vector, an output vector and a per-bit output-enable vector, so a wrapper at the chip edge can build tristate nets. A port that is not driving reports an all-zero enable vector and an all-zero output vector.

Top module: `bank_latch_mux`

## Requirements
- R1: While `rstN` is low, all three output-enable vectors and all three output vectors are zero, whatever the drive controls are. Reset clears all four stored words to zero, so a port enabled after reset without any capture presents zero.
- R2: While `capAtoB1` (or `capAtoB2`) is high and the matching bank drive control is low, that bank's output equals `aIn` in the same cycle.
- R3: A stage stores its input at every rising clock edge where its capture enable is high. While the enable is low, it presents the word stored at the last such edge. Changes on its input during that time have no effect on the output.
- R4: The two outbound stages are independent. Capturing into one bank leaves the word held for the other bank unchanged.
- R5: While `capB1toA` (or `capB2toA`) is high, the inbound stage for that bank follows that bank's input in the same cycle. When the enable falls, the stage holds the word as R3 describes.
- R6: When `aDriveN` is low, `aOut` shows the bank-1 inbound stage while `bankSel` is 1 and the bank-2 inbound stage while `bankSel` is 0.
- R7: When `aDriveN` is high, `aOe` and `aOut` are all zero, regardless of `bankSel` and of the stored words.
- R8: `bank1DriveN` and `bank2DriveN` act independently. Neither, either or both banks may drive at the same time. A bank whose control is high shows all-zero enable and output vectors.
- R9: Each output-enable vector is always either all ones (the port is driving) or all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stages store on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 12 | Word arriving on side A |
| aOut | output | 12 | Word driven onto side A (zero when not driving) |
| aOe | output | 12 | Per-bit drive enable for side A |
| b1In | input | 12 | Word arriving on bank 1 |
| b1Out | output | 12 | Word driven onto bank 1 (zero when not driving) |
| b1Oe | output | 12 | Per-bit drive enable for bank 1 |
| b2In | input | 12 | Word arriving on bank 2 |
| b2Out | output | 12 | Word driven onto bank 2 (zero when not driving) |
| b2Oe | output | 12 | Per-bit drive enable for bank 2 |
| capAtoB1 | input | 1 | Capture enable, side A toward bank 1 (high = transparent) |
| capAtoB2 | input | 1 | Capture enable, side A toward bank 2 (high = transparent) |
| capB1toA | input | 1 | Capture enable, bank 1 toward side A (high = transparent) |
| capB2toA | input | 1 | Capture enable, bank 2 toward side A (high = transparent) |
| bankSel | input | 1 | Inbound select: 1 = bank 1, 0 = bank 2 |
| aDriveN | input | 1 | Active-low drive control for side A |
| bank1DriveN | input | 1 | Active-low drive control for bank 1 |
| bank2DriveN | input | 1 | Active-low drive control for bank 2 |

## Verification
The assertions assume that every input is already at a known level when the first clock edge arrives, and that `rstN` is held low from time zero. This matters because the reset and hold properties compare against values sampled in the previous cycle. Each capture input is also assumed to be stable across the sampling edge, which stands in for the setup and hold window around the falling enable. The stimulus changes every input just after a falling clock edge, starts with reset asserted, and tests each direction while the drive controls of the other direction are inactive. It then rewrites the stage inputs after each enable falls, to show that the held words survive.

// File: rtl/bank_latch_pkg.sv
`timescale 1ns/1ps
package bank_latch_pkg;

  // Index of each holding stage inside the datapath array.
  localparam int unsigned NUM_STAGES = 4;
  localparam int unsigned STG_A_B1 = 0;
  localparam int unsigned STG_A_B2 = 1;
  localparam int unsigned STG_B1_A = 2;
  localparam int unsigned STG_B2_A = 3;

  // Strobes from control to datapath, already qualified by reset.
  typedef struct packed {
    logic capAB1;
    logic capAB2;
    logic capB1A;
    logic capB2A;
    logic driveA;
    logic driveB1;
    logic driveB2;
    logic pickB1;
  } ctrlStrobe_t;

endpackage

// File: rtl/bank_latch_cell.sv
`timescale 1ns/1ps
module bank_latch_cell #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         capEn,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= '0;
    end else if (capEn) begin
      held <= din;
    end
  end

  // Transparent view while the enable is high, stored word otherwise.
  assign q = capEn ? din : held;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!capEn && $past(!capEn)) |-> $stable(q)); // R3

  AST_CAPTURE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(capEn) |-> (q == $past(din))); // R3

endmodule

// File: rtl/bank_latch_ctrl.sv
`timescale 1ns/1ps
module bank_latch_ctrl
  import bank_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        capAtoB1,
  input  logic        capAtoB2,
  input  logic        capB1toA,
  input  logic        capB2toA,
  input  logic        bankSel,
  input  logic        aDriveN,
  input  logic        bank1DriveN,
  input  logic        bank2DriveN,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.capAB1  = rstN & capAtoB1;
    strobe.capAB2  = rstN & capAtoB2;
    strobe.capB1A  = rstN & capB1toA;
    strobe.capB2A  = rstN & capB2toA;
    strobe.driveA  = rstN & ~aDriveN;
    strobe.driveB1 = rstN & ~bank1DriveN;
    strobe.driveB2 = rstN & ~bank2DriveN;
    strobe.pickB1  = bankSel;
  end

  // Inbound drive must not be granted while side A control is inactive.
  AST_A_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    aDriveN |-> !strobe.driveA); // R7

endmodule

// File: rtl/bank_latch_datapath.sv
`timescale 1ns/1ps
module bank_latch_datapath
  import bank_latch_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobe_t  strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b1In,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOe,
  output logic [W-1:0] b1Out,
  output logic [W-1:0] b1Oe,
  output logic [W-1:0] b2Out,
  output logic [W-1:0] b2Oe
);

  logic [W-1:0]          stgD [NUM_STAGES];
  logic [W-1:0]          stgQ [NUM_STAGES];
  logic [NUM_STAGES-1:0] stgCap;
  logic [W-1:0]          inboundWord;

  always_comb begin
    stgD[STG_A_B1] = aIn;
    stgD[STG_A_B2] = aIn;
    stgD[STG_B1_A] = b1In;
    stgD[STG_B2_A] = b2In;
    stgCap[STG_A_B1] = strobe.capAB1;
    stgCap[STG_A_B2] = strobe.capAB2;
    stgCap[STG_B1_A] = strobe.capB1A;
    stgCap[STG_B2_A] = strobe.capB2A;
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gStage
    bank_latch_cell #(.W(W)) u_cell (
      .clk  (clk),
      .rstN (rstN),
      .capEn(stgCap[g]),
      .din  (stgD[g]),
      .q    (stgQ[g])
    );
  end

  assign inboundWord = strobe.pickB1 ? stgQ[STG_B1_A] : stgQ[STG_B2_A];

  assign aOut  = strobe.driveA  ? inboundWord    : '0;
  assign b1Out = strobe.driveB1 ? stgQ[STG_A_B1] : '0;
  assign b2Out = strobe.driveB2 ? stgQ[STG_A_B2] : '0;
  assign aOe   = {W{strobe.driveA}};
  assign b1Oe  = {W{strobe.driveB1}};
  assign b2Oe  = {W{strobe.driveB2}};

  // Capturing into bank 1 alone must leave the bank-2 word alone.
  AST_BANK_ISOLATION: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capAB2 && $past(!strobe.capAB2)) |-> $stable(stgQ[STG_A_B2])); // R4

endmodule

// File: rtl/bank_latch_mux.sv
`timescale 1ns/1ps
module bank_latch_mux
  import bank_latch_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOe,
  input  logic [W-1:0] b1In,
  output logic [W-1:0] b1Out,
  output logic [W-1:0] b1Oe,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] b2Out,
  output logic [W-1:0] b2Oe,
  input  logic         capAtoB1,
  input  logic         capAtoB2,
  input  logic         capB1toA,
  input  logic         capB2toA,
  input  logic         bankSel,
  input  logic         aDriveN,
  input  logic         bank1DriveN,
  input  logic         bank2DriveN
);

  ctrlStrobe_t strobe;

  bank_latch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .capAtoB1   (capAtoB1),
    .capAtoB2   (capAtoB2),
    .capB1toA   (capB1toA),
    .capB2toA   (capB2toA),
    .bankSel    (bankSel),
    .aDriveN    (aDriveN),
    .bank1DriveN(bank1DriveN),
    .bank2DriveN(bank2DriveN),
    .strobe     (strobe)
  );

  bank_latch_datapath #(.W(W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .aIn   (aIn),
    .b1In  (b1In),
    .b2In  (b2In),
    .aOut  (aOut),
    .aOe   (aOe),
    .b1Out (b1Out),
    .b1Oe  (b1Oe),
    .b2Out (b2Out),
    .b2Oe  (b2Oe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (aOe == '0 && b1Oe == '0 && b2Oe == '0 &&
               aOut == '0 && b1Out == '0 && b2Out == '0)); // R1

  AST_A_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    aDriveN |-> (aOe == '0 && aOut == '0)); // R7

  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rstN)
    (aOe == '0 || aOe == '1) && (b1Oe == '0 || b1Oe == '1) &&
    (b2Oe == '0 || b2Oe == '1)); // R9

  AST_BANK_DRIVE_INDEP: assert property (@(posedge clk) disable iff (!rstN)
    (bank1DriveN |-> b1Oe == '0) and (bank2DriveN |-> b2Oe == '0)); // R8

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!aDriveN && $past(!aDriveN) && $stable(bankSel) &&
     !capB1toA && !capB2toA && $past(!capB1toA && !capB2toA))
    |-> $stable(aOut)); // R6

endmodule

// File: tb/bank_latch_mux_tb.sv
`timescale 1ns/1ps
module bank_latch_mux_tb;

  localparam int unsigned W = 12;
  localparam int unsigned MAX_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] aIn = '0, b1In = '0, b2In = '0;
  logic [W-1:0] aOut, aOe, b1Out, b1Oe, b2Out, b2Oe;
  logic         capAtoB1 = 0, capAtoB2 = 0, capB1toA = 0, capB2toA = 0;
  logic         bankSel = 0;
  logic         aDriveN = 1, bank1DriveN = 1, bank2DriveN = 1;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bank_latch_mux #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .b1In(b1In), .b1Out(b1Out), .b1Oe(b1Oe),
    .b2In(b2In), .b2Out(b2Out), .b2Oe(b2Oe),
    .capAtoB1(capAtoB1), .capAtoB2(capAtoB2),
    .capB1toA(capB1toA), .capB2toA(capB2toA),
    .bankSel(bankSel), .aDriveN(aDriveN),
    .bank1DriveN(bank1DriveN), .bank2DriveN(bank2DriveN)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance one clock: through the rising edge, then to the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    aDriveN = 0; bank1DriveN = 0; bank2DriveN = 0; bankSel = 1;
    aIn = 12'hFFF; b1In = 12'hFFF; b2In = 12'hFFF;
    capAtoB1 = 1; capB1toA = 1;
    repeat (3) tick();
    settle();
    check("R1 aOe in reset", aOe, '0);
    check("R1 b1Oe in reset", b1Oe, '0);
    check("R1 b2Out in reset", b2Out, '0);
    check("R1 aOut in reset", aOut, '0);
    capAtoB1 = 0; capB1toA = 0;
    aDriveN = 1; bank1DriveN = 1; bank2DriveN = 1;
    rstN = 1;
    tick();
    settle();
    check("R1 aOe after reset, control inactive", aOe, '0);
    bank1DriveN = 0; aDriveN = 0;
    settle();
    check("R1 b1Out cleared word", b1Out, '0);
    check("R1 aOut cleared word", aOut, '0);
    check("R9 b1Oe all ones", b1Oe, '1);
    aDriveN = 1; bank1DriveN = 1;
  endtask

  task automatic t_a_to_b1();
    bank1DriveN = 0;
    capAtoB1 = 1; aIn = 12'hA5A;
    settle();
    check("R2 bank1 transparent", b1Out, 12'hA5A);
    aIn = 12'h5C3;
    settle();
    check("R2 bank1 follows same cycle", b1Out, 12'h5C3);
    tick();                       // stores 5C3
    capAtoB1 = 0; aIn = 12'h123;
    settle();
    check("R3 bank1 holds after enable falls", b1Out, 12'h5C3);
    tick();
    aIn = 12'h0F0;
    tick();
    settle();
    check("R3 bank1 ignores input while held", b1Out, 12'h5C3);
  endtask

  task automatic t_bank_indep();
    capAtoB2 = 1; aIn = 12'h3C3;
    tick();
    capAtoB2 = 0; aIn = 12'h777;
    bank2DriveN = 0;
    settle();
    check("R4 bank2 holds own word", b2Out, 12'h3C3);
    check("R4 bank1 word untouched", b1Out, 12'h5C3);
    check("R8 both banks drive", b1Oe & b2Oe, '1);
    bank1DriveN = 1;
    settle();
    check("R8 bank1 off enable", b1Oe, '0);
    check("R8 bank1 off data", b1Out, '0);
    check("R8 bank2 still drives", b2Out, 12'h3C3);
    bank2DriveN = 1;
    settle();
    check("R8 neither drives", b1Oe | b2Oe, '0);
  endtask

  task automatic t_b_to_a();
    aDriveN = 0; bankSel = 1;
    capB1toA = 1; b1In = 12'h111;
    settle();
    check("R5 inbound bank1 transparent", aOut, 12'h111);
    check("R9 aOe all ones", aOe, '1);
    tick();
    capB1toA = 0; b1In = 12'hFFF;
    settle();
    check("R5 inbound bank1 held", aOut, 12'h111);
    capB2toA = 1; b2In = 12'h222;
    tick();
    capB2toA = 0; b2In = 12'h999;
    settle();
    check("R6 select 1 gives bank1", aOut, 12'h111);
    bankSel = 0;
    settle();
    check("R6 select 0 gives bank2", aOut, 12'h222);
    tick();
    settle();
    check("R3 inbound bank2 held across cycles", aOut, 12'h222);
  endtask

  task automatic t_a_disable();
    aDriveN = 1;
    settle();
    check("R7 aOe off", aOe, '0);
    check("R7 aOut off", aOut, '0);
    bankSel = 1; capB1toA = 1; b1In = 12'hABC;
    settle();
    check("R7 aOut off despite transparent stage", aOut, '0);
    tick();
    capB1toA = 0;
    aDriveN = 0;
    settle();
    check("R5 word stored while A idle", aOut, 12'hABC);
    aDriveN = 1;
  endtask

  task automatic t_mid_reset();
    rstN = 0;
    settle();
    check("R1 outputs off at reset entry", b2Oe | aOe, '0);
    tick();
    rstN = 1;
    tick();
    aDriveN = 0; bankSel = 1; bank2DriveN = 0;
    settle();
    check("R1 inbound word cleared", aOut, '0);
    check("R1 outbound word cleared", b2Out, '0);
    aDriveN = 1; bank2DriveN = 1;
  endtask

  initial begin
    #(MAX_CYCLES * 4);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_a_to_b1();
    t_bank_indep();
    t_b_to_a();
    t_a_disable();
    t_mid_reset();
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule